// File: doc/BRIEF.md
# Page-buffered write cycle sequencer

This block sits behind the command decoder of a serial byte-wide memory. It gathers the data bytes of one write transaction into a 16-entry page buffer. Once the transaction has closed properly, it copies those bytes into a register storage array during a self-timed program cycle of fixed length. The decoder opens a transaction with a start address and then hands over each received byte. Chip-select logic gives a strobe when the select line rises, together with a flag that says whether a byte was left incomplete. A protection unit watches the address of the byte being loaded and returns a verdict on it.

While the program cycle runs, the block reports busy and ignores any new transaction traffic. In the final busy cycle it pulses a request that clears the write-enable latch. A read port lets the read path, or a test, see what the array holds.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` is 0, `prog_we` is 0 and `wel_clr` is 0.
- R2: The first byte of a transaction loads at `start_addr`. Each later byte loads at the next value of the low 4 address bits, modulo 16, and the page bits (`ADDR_W-1:4`) never change. `load_addr` always shows the address that the next byte will take.
- R3: When more than 16 bytes arrive, loading wraps to the start of the same page. A later byte replaces the earlier byte at the same offset, and only the last value is programmed.
- R4: The array does not change while the transaction is still open. Programming happens only after `cs_rise` closes a valid transaction.
- R5: No program cycle starts, and the array is left unchanged, if the transaction closes with zero bytes loaded or with `frag_pending` = 1.
- R6: A valid close makes `busy` go to 1 on the next clock. It then stays 1 for exactly `WC_CYCLES` cycles (`WC_CYCLES` >= 16).
- R7: While `busy` is 1, `txn_start`, `byte_valid` and `cs_rise` are ignored. No transaction opens, no byte loads, and the program cycle goes on as before.
- R8: `wel_clr` is 1 for exactly one cycle per program cycle, and that cycle is the last cycle in which `busy` is 1.
- R9: If `wp_n` is 0 in any cycle while a transaction is open, including the closing cycle, the transaction is abandoned. If `wp_n` is 0 during a program cycle, the cycle is not affected.
- R10: Only the page offsets loaded in the transaction are written. The other bytes of the page keep their old contents.
- R11: If `prot_hit` is 1 with any loaded byte, the whole transaction is discarded.
- R12: Array writes (`prog_we` = 1) happen only while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Opens a write transaction at `start_addr` |
| start_addr | input | ADDR_W | First byte address of the transaction |
| byte_valid | input | 1 | A received data byte is present on `byte_data` |
| byte_data | input | 8 | Received data byte |
| prot_hit | input | 1 | The protection unit judges `load_addr` to be protected (sampled with `byte_valid`) |
| cs_rise | input | 1 | Chip select has risen and the transaction is closing |
| frag_pending | input | 1 | Bits of an incomplete byte were received when `cs_rise` arrived |
| wp_n | input | 1 | Write-protect level; 0 inhibits writes |
| rd_addr | input | ADDR_W | Read-port address |
| rd_data | output | 8 | Array contents at `rd_addr` |
| load_addr | output | ADDR_W | Address that the next loaded byte will take |
| busy | output | 1 | A program cycle is running |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| prog_we | output | 1 | Array write strobe |
| prog_addr | output | ADDR_W | Array write address |
| prog_data | output | 8 | Array write data |

## Verification
On every cycle, the assertions check the following:
- the program cycle has exactly the set length;
- a cycle starts only after a close strobe;
- array strobes appear only while busy;
- the latch-clear pulse lines up with the fall of busy;
- the load pointer stays frozen during a program cycle.

Only the bench scenarios can show the effects on the data:
- what the page holds after wrapping;
- that unloaded offsets are preserved;
- that abandoned, fragmented and protected transactions leave the array untouched.

The bench checks these by comparing the whole array with an arithmetic model after each transaction.

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int WC_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              prot_hit,
  input  logic              cs_rise,
  input  logic              frag_pending,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] load_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data
);
  localparam int PAGE_SZ = 1 << PAGE_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HI_W    = ADDR_W - PAGE_W;
  localparam int TW      = $clog2(WC_CYCLES + 1);

  logic              loading_q, abort_q, any_q, busy_q;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PAGE_SZ-1:0] mask_q;
  logic [PAGE_W:0]   idx_q;
  logic [TW-1:0]     tmr_q;
  logic [7:0]        buf_q [PAGE_SZ];
  logic [7:0]        mem_q [DEPTH];

  wire last_cyc = busy_q && (tmr_q == TW'(WC_CYCLES - 1));
  wire take     = loading_q && !cs_rise && byte_valid;
  wire commit   = loading_q && cs_rise && any_q && !abort_q && !frag_pending && wp_n;

  assign busy      = busy_q;
  assign wel_clr   = last_cyc;
  assign load_addr = {page_q, ptr_q};
  assign prog_we   = busy_q && !idx_q[PAGE_W] && mask_q[idx_q[PAGE_W-1:0]];
  assign prog_addr = {page_q, idx_q[PAGE_W-1:0]};
  assign prog_data = buf_q[idx_q[PAGE_W-1:0]];
  assign rd_data   = mem_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b0;
      abort_q   <= 1'b0;
      any_q     <= 1'b0;
      busy_q    <= 1'b0;
      page_q    <= '0;
      ptr_q     <= '0;
      mask_q    <= '0;
      idx_q     <= '0;
      tmr_q     <= '0;
    end else if (busy_q) begin
      tmr_q <= tmr_q + 1'b1;
      if (!idx_q[PAGE_W]) idx_q <= idx_q + 1'b1;
      if (last_cyc) busy_q <= 1'b0;
    end else if (loading_q) begin
      if (cs_rise) begin
        loading_q <= 1'b0;
        if (commit) begin
          busy_q <= 1'b1;
          tmr_q  <= '0;
          idx_q  <= '0;
        end
      end else begin
        if (!wp_n) abort_q <= 1'b1;
        if (take) begin
          mask_q[ptr_q] <= 1'b1;
          ptr_q         <= ptr_q + 1'b1;
          any_q         <= 1'b1;
          if (prot_hit) abort_q <= 1'b1;
        end
      end
    end else if (txn_start) begin
      loading_q <= 1'b1;
      page_q    <= start_addr[ADDR_W-1:PAGE_W];
      ptr_q     <= start_addr[PAGE_W-1:0];
      mask_q    <= '0;
      any_q     <= 1'b0;
      abort_q   <= !wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[ptr_q] <= byte_data;
    if (prog_we) mem_q[prog_addr] <= prog_data;
  end
endmodule

module page_write_seq_chk #(
  parameter int ADDR_W    = 9,
  parameter int WC_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cs_rise,
  input logic              prog_we,
  input logic              wel_clr,
  input logic [ADDR_W-1:0] load_addr
);
  localparam int TW = $clog2(WC_CYCLES + 2);
  logic [TW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= '0;
    else        bcnt <= busy ? bcnt + 1'b1 : '0;

  assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < TW'(WC_CYCLES));
  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == TW'(WC_CYCLES));
  assert_start_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  assert_we_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |-> busy);
  assert_clr_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);
  assert_fall_after_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wel_clr));
  assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(load_addr));
endmodule

bind page_write_seq page_write_seq_chk #(.ADDR_W(ADDR_W), .WC_CYCLES(WC_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_rise(cs_rise),
  .prog_we(prog_we), .wel_clr(wel_clr), .load_addr(load_addr)
);

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;
  localparam int AW = 6;
  localparam int WC = 24;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic txn_start = 0, byte_valid = 0, prot_hit = 0, cs_rise = 0, frag_pending = 0, wp_n = 1;
  logic [AW-1:0] start_addr = 0, rd_addr = 0;
  logic [7:0] byte_data = 0;
  logic [7:0] rd_data, prog_data;
  logic [AW-1:0] load_addr, prog_addr;
  logic busy, wel_clr, prog_we;

  int total = 0, bad = 0;
  int plim = DEPTH;
  logic [7:0] exp_mem [DEPTH];

  always #4 clk = ~clk;

  page_write_seq #(.ADDR_W(AW), .PAGE_W(4), .WC_CYCLES(WC)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #1;
      chk(req, rd_data, exp_mem[a]);
    end
  endtask

  // n bytes from sa; wp_at: byte index at which wp_n dips low (-1 none)
  task automatic txn(input int sa, input int n, input int seed, input bit frag,
                     input int wp_at, input string req);
    bit ok;
    bit hit = 0;
    int bcnt, ccnt;
    logic [7:0] nd [16];
    bit nv [16];
    for (int k = 0; k < 16; k++) nv[k] = 0;
    start_addr = AW'(sa);
    txn_start = 1;
    @(negedge clk);
    txn_start = 0;
    for (int i = 0; i < n; i++) begin
      int a = (sa & ~15) | ((sa + i) & 15);
      chk("R2", load_addr, a);
      byte_valid = 1;
      byte_data = 8'(seed + i * 7);
      prot_hit = (a >= plim);
      if (prot_hit) hit = 1;
      wp_n = (i != wp_at);
      nd[a & 15] = byte_data;
      nv[a & 15] = 1;
      @(negedge clk);
      byte_valid = 0; prot_hit = 0; wp_n = 1;
    end
    if (n > 0) begin
      rd_addr = AW'(sa);
      #1;
      chk("R4", rd_data, exp_mem[sa]);
    end
    ok = (n > 0) && !frag && (wp_at < 0 || wp_at >= n) && !hit;
    frag_pending = frag;
    cs_rise = 1;
    @(negedge clk);
    cs_rise = 0; frag_pending = 0;
    chk(req, busy, ok);
    if (ok) begin
      bcnt = 0; ccnt = 0;
      while (busy && bcnt < 4 * WC) begin
        if (wel_clr) begin
          ccnt++;
          chk("R8", bcnt, WC - 1);
        end
        // R7/R9 junk traffic while busy
        txn_start = 1; byte_valid = 1; cs_rise = bcnt[0]; byte_data = 8'hEE;
        start_addr = 0; wp_n = bcnt[1];
        @(negedge clk);
        bcnt++;
      end
      txn_start = 0; byte_valid = 0; cs_rise = 0; wp_n = 1;
      chk("R6", bcnt, WC);
      chk("R8", ccnt, 1);
      for (int k = 0; k < 16; k++)
        if (nv[k]) exp_mem[(sa & ~15) | k] = nd[k];
      cs_rise = 1;
      @(negedge clk);
      cs_rise = 0;
      @(negedge clk);
      chk("R7", busy, 0);
    end
    compare_all(req);
  endtask

  initial begin : wdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3;
    chk("R1", busy, 0); chk("R1", prog_we, 0); chk("R1", wel_clr, 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1", busy, 0);
    for (int p = 0; p < DEPTH / 16; p++) txn(p * 16, 16, p * 40 + 3, 0, -1, "R10");
    txn(14, 3, 100, 0, -1, "R2");
    txn(16 + 5, 20, 150, 0, -1, "R3");
    txn(32 + 9, 1, 77, 0, -1, "R10");
    txn(40, 0, 0, 0, -1, "R5");
    txn(44, 4, 90, 1, -1, "R5");
    txn(50, 5, 60, 0, 2, "R9");
    plim = 48;
    txn(56, 3, 33, 0, -1, "R11");
    txn(44, 6, 200, 0, -1, "R11");
    plim = DEPTH;
    txn(60, 7, 11, 0, -1, "R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule